// File: doc/BRIEF.md
# Three-Wire Framed Serial Configuration Port

This block takes configuration words from a slow three-wire serial bus (a serial clock, a data line and an active-low select) and turns them into the settings of a frequency-synthesis and gain stage. While select is low, each rising edge of the serial clock shifts one data bit into a 14-bit word, most significant bit first. The block does not count the serial clock pulses. Whatever arrives, only the last 14 bits are kept. When select goes back high, the two bits that arrived last act as an address. That address picks one of three target registers, and the twelve bits before it are copied into that register.

The three targets have different layouts. The reference register holds a 2-bit modulator reference select and an 8-bit converter reference ratio. The control register holds an output-enable flag, a 3-bit charge-pump code and a 5-bit gain code. The divider register holds a 12-bit main divider ratio. Address 00 names no target, so a word sent with it is dropped. Each target raises a one-cycle load strobe on the cycle its new value appears, so downstream counters can reload.

The three serial lines are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the serial clock and select edges are detected in the system clock domain. All register outputs are registered. A synchronous active-high reset clears every output.

Top module: `serial_cfg_port`

## Requirements
- R1: After reset, every field output is zero and every load strobe is low.
- R2: Rising serial clock edges that occur while `ser_sel_n` is high shift nothing, and no field or strobe changes.
- R3: While `ser_sel_n` is low, each rising serial clock edge shifts `ser_dat` into the word, MSB first. Only the last 14 bits shifted are kept, whatever the number of edges in the frame.
- R4: Field outputs change only after `ser_sel_n` goes from low to high, never during a frame.
- R5: A word ending in address bits 01 loads the reference register. Word bits [11:10] go to `mod_ref_sel` and word bits [9:2] go to `conv_ref_ratio`. Word bits [13:12] are ignored.
- R6: A word ending in address bits 10 loads the control register. Word bit [10] goes to `out_enable` (1 = enabled), word bits [9:7] go to `cp_code`, and word bits [6:2] go to `gain_code` (0 = minimum gain, 31 = maximum gain). Word bits [13:11] are ignored.
- R7: A word ending in address bits 11 loads word bits [13:2] into `main_ratio`.
- R8: A word ending in address bits 00 is discarded: no field changes and no strobe fires.
- R9: Each load raises only the strobe of the register loaded (`ref_load`, `ctl_load` or `div_load`), for exactly one cycle. The strobe is high in the same cycle that the new field value first appears.
- R10: Loading one register leaves the fields of the other two registers unchanged.

Word bit 0 is the last bit shifted in and word bit 13 is the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial bus clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial bus data |
| ser_sel_n | input | 1 | Serial frame select, active low; the low-to-high edge commits the frame |
| mod_ref_sel | output | 2 | Modulator reference divider select |
| conv_ref_ratio | output | 8 | Converter reference divider ratio |
| out_enable | output | 1 | Output amplifier enable |
| cp_code | output | 3 | Converter charge-pump current code |
| gain_code | output | 5 | Gain DAC code |
| main_ratio | output | 12 | Programmable main divider ratio |
| ref_load | output | 1 | One-cycle strobe: reference register updated |
| ctl_load | output | 1 | One-cycle strobe: control register updated |
| div_load | output | 1 | One-cycle strobe: divider register updated |

## Verification
Exact 14-bit frames are sent to each of the three addresses. The bit values are chosen so that any misplaced field slice or reversed bit order produces a wrong value. The don't-care bits are set to ones, so a leak from them would also show.

An 18-bit frame shows that the leading surplus bits fall out and only the trailing word counts. A short 7-bit frame, sent after clock pulses given while select was high, can only decode to the expected word if those pulses shifted nothing. In that case the word is made of bits left from the previous frame plus the seven new ones.

A frame with address 00, and checks taken before select rises, show that fields and strobes stay quiet when they should. Counting strobe pulses, and capturing the fields in the strobe cycle, separates the three strobes from each other and pins down when each one fires.

// File: rtl/scfg_pkg.sv
package scfg_pkg;
  // serial word layout: {data, address}, address shifted in last
  localparam int WORD_W = 14;
  localparam int ADDR_W = 2;
  localparam int DATA_W = WORD_W - ADDR_W;

  // field widths inside the data part
  localparam int MSEL_W = 2;
  localparam int CREF_W = 8;
  localparam int CP_W   = 3;
  localparam int GAIN_W = 5;
  localparam int MAIN_W = 12;

  // number of addressable targets (address 0 is unused)
  localparam int NUM_TGT = 3;

  typedef enum logic [ADDR_W-1:0] {
    TGT_NONE = 2'b00,
    TGT_REF  = 2'b01,
    TGT_CTL  = 2'b10,
    TGT_DIV  = 2'b11
  } tgt_e;
endpackage

// File: rtl/scfg_sync.sv
module scfg_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/scfg_shifter.sv
module scfg_shifter #(
  parameter int WORD_W = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdat_s,
  input  logic              sel_n_s,
  output logic [WORD_W-1:0] word,
  output logic              commit
);
  logic sclk_q;
  logic sel_n_q;
  logic sclk_rise;

  assign sclk_rise = sclk_s & ~sclk_q;
  // frame ends on the low-to-high transition of the select line
  assign commit    = sel_n_s & ~sel_n_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q  <= 1'b0;
      sel_n_q <= 1'b1;
      word    <= '0;
    end else begin
      sclk_q  <= sclk_s;
      sel_n_q <= sel_n_s;
      if (sclk_rise && !sel_n_s)
        word <= {word[WORD_W-2:0], sdat_s};
    end
  end
endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [WORD_W-1:0] word,
  output logic [MSEL_W-1:0] mod_ref_sel,
  output logic [CREF_W-1:0] conv_ref_ratio,
  output logic              out_enable,
  output logic [CP_W-1:0]   cp_code,
  output logic [GAIN_W-1:0] gain_code,
  output logic [MAIN_W-1:0] main_ratio,
  output logic              ref_load,
  output logic              ctl_load,
  output logic              div_load
);
  logic [ADDR_W-1:0]  addr;
  logic [DATA_W-1:0]  data;
  logic [NUM_TGT-1:0] hit;
  logic [NUM_TGT-1:0] stb_q;

  assign addr = word[ADDR_W-1:0];
  assign data = word[WORD_W-1:ADDR_W];

  // one decode per target; target k answers to address k+1
  for (genvar k = 0; k < NUM_TGT; k++) begin : g_dec
    assign hit[k] = commit && (addr == ADDR_W'(k + 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_ref_sel    <= '0;
      conv_ref_ratio <= '0;
      out_enable     <= 1'b0;
      cp_code        <= '0;
      gain_code      <= '0;
      main_ratio     <= '0;
      stb_q          <= '0;
    end else begin
      stb_q <= hit;
      if (hit[int'(TGT_REF) - 1]) begin
        conv_ref_ratio <= data[CREF_W-1:0];
        mod_ref_sel    <= data[CREF_W +: MSEL_W];
      end
      if (hit[int'(TGT_CTL) - 1]) begin
        gain_code  <= data[GAIN_W-1:0];
        cp_code    <= data[GAIN_W +: CP_W];
        out_enable <= data[GAIN_W + CP_W];
      end
      if (hit[int'(TGT_DIV) - 1]) begin
        main_ratio <= data[MAIN_W-1:0];
      end
    end
  end

  assign ref_load = stb_q[int'(TGT_REF) - 1];
  assign ctl_load = stb_q[int'(TGT_CTL) - 1];
  assign div_load = stb_q[int'(TGT_DIV) - 1];
endmodule

// File: rtl/serial_cfg_port.sv
module serial_cfg_port
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_sel_n,
  output logic [MSEL_W-1:0] mod_ref_sel,
  output logic [CREF_W-1:0] conv_ref_ratio,
  output logic              out_enable,
  output logic [CP_W-1:0]   cp_code,
  output logic [GAIN_W-1:0] gain_code,
  output logic [MAIN_W-1:0] main_ratio,
  output logic              ref_load,
  output logic              ctl_load,
  output logic              div_load
);
  // synchronized lines, ordered {select, data, clock}; select idles high
  logic [2:0]        lines_s;
  logic [WORD_W-1:0] word;
  logic              commit;

  scfg_sync #(
    .W       (3),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ser_sel_n, ser_dat, ser_clk}),
    .q   (lines_s)
  );

  scfg_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .sclk_s  (lines_s[0]),
    .sdat_s  (lines_s[1]),
    .sel_n_s (lines_s[2]),
    .word    (word),
    .commit  (commit)
  );

  scfg_regs u_regs (
    .clk            (clk),
    .rst            (rst),
    .commit         (commit),
    .word           (word),
    .mod_ref_sel    (mod_ref_sel),
    .conv_ref_ratio (conv_ref_ratio),
    .out_enable     (out_enable),
    .cp_code        (cp_code),
    .gain_code      (gain_code),
    .main_ratio     (main_ratio),
    .ref_load       (ref_load),
    .ctl_load       (ctl_load),
    .div_load       (div_load)
  );
endmodule

// File: rtl/serial_cfg_port_chk.sv
module serial_cfg_port_chk
  import scfg_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [MSEL_W-1:0] mod_ref_sel,
  input logic [CREF_W-1:0] conv_ref_ratio,
  input logic              out_enable,
  input logic [CP_W-1:0]   cp_code,
  input logic [GAIN_W-1:0] gain_code,
  input logic [MAIN_W-1:0] main_ratio,
  input logic              ref_load,
  input logic              ctl_load,
  input logic              div_load
);
  // R1: reset clears all outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (mod_ref_sel == '0 && conv_ref_ratio == '0 && !out_enable &&
             cp_code == '0 && gain_code == '0 && main_ratio == '0 &&
             !ref_load && !ctl_load && !div_load));

  // R9: at most one strobe at a time
  a_r9_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_load, ctl_load, div_load}));

  // R9: strobes last a single cycle
  a_r9_ref_pulse: assert property (@(posedge clk) disable iff (rst)
    ref_load |=> !ref_load);
  a_r9_ctl_pulse: assert property (@(posedge clk) disable iff (rst)
    ctl_load |=> !ctl_load);
  a_r9_div_pulse: assert property (@(posedge clk) disable iff (rst)
    div_load |=> !div_load);

  // R4 / R10: a field only moves in the cycle its own strobe is high
  a_r10_ref_hold: assert property (@(posedge clk) disable iff (rst)
    !ref_load |-> ($stable(mod_ref_sel) && $stable(conv_ref_ratio)));
  a_r10_ctl_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl_load |-> ($stable(out_enable) && $stable(cp_code) && $stable(gain_code)));
  a_r10_div_hold: assert property (@(posedge clk) disable iff (rst)
    !div_load |-> $stable(main_ratio));
endmodule

bind serial_cfg_port serial_cfg_port_chk u_chk (
  .clk            (clk),
  .rst            (rst),
  .mod_ref_sel    (mod_ref_sel),
  .conv_ref_ratio (conv_ref_ratio),
  .out_enable     (out_enable),
  .cp_code        (cp_code),
  .gain_code      (gain_code),
  .main_ratio     (main_ratio),
  .ref_load       (ref_load),
  .ctl_load       (ctl_load),
  .div_load       (div_load)
);

// File: tb/serial_cfg_port_tb_top.sv
module serial_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0;
  logic ser_dat = 1'b0;
  logic ser_sel_n = 1'b1;

  logic [1:0]  mod_ref_sel;
  logic [7:0]  conv_ref_ratio;
  logic        out_enable;
  logic [2:0]  cp_code;
  logic [4:0]  gain_code;
  logic [11:0] main_ratio;
  logic        ref_load, ctl_load, div_load;

  serial_cfg_port dut_i (
    .clk (clk), .rst (rst),
    .ser_clk (ser_clk), .ser_dat (ser_dat), .ser_sel_n (ser_sel_n),
    .mod_ref_sel (mod_ref_sel), .conv_ref_ratio (conv_ref_ratio),
    .out_enable (out_enable), .cp_code (cp_code), .gain_code (gain_code),
    .main_ratio (main_ratio),
    .ref_load (ref_load), .ctl_load (ctl_load), .div_load (div_load)
  );

  always #10 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model of the shift word and the expected fields
  logic [13:0] mdl = '0;
  int e_msel = 0, e_cref = 0, e_oen = 0, e_cp = 0, e_gain = 0, e_main = 0;

  // strobe monitors, sampled away from the active edge
  int n_ref = 0, n_ctl = 0, n_div = 0;
  int cap_cref = 0, cap_gain = 0, cap_main = 0;
  always @(negedge clk) begin
    if (!rst) begin
      if (ref_load) begin n_ref++; cap_cref = int'(conv_ref_ratio); end
      if (ctl_load) begin n_ctl++; cap_gain = int'(gain_code); end
      if (div_load) begin n_div++; cap_main = int'(main_ratio); end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_sys(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = v[i];
      wait_sys(3);
      ser_clk = 1'b1;
      if (!ser_sel_n) mdl = {mdl[12:0], v[i]};
      wait_sys(3);
      ser_clk = 1'b0;
    end
  endtask

  task automatic open_frame();
    ser_sel_n = 1'b0;
    wait_sys(4);
  endtask

  task automatic close_frame();
    wait_sys(3);
    ser_sel_n = 1'b1;
    case (mdl[1:0])
      2'b01: begin e_msel = int'(mdl[11:10]); e_cref = int'(mdl[9:2]); end
      2'b10: begin e_oen = int'(mdl[10]); e_cp = int'(mdl[9:7]); e_gain = int'(mdl[6:2]); end
      2'b11: e_main = int'(mdl[13:2]);
      default: ;
    endcase
    wait_sys(8);
  endtask

  task automatic check_fields(input string tag);
    chk({tag, " mod_ref_sel"},    int'(mod_ref_sel),    e_msel);
    chk({tag, " conv_ref_ratio"}, int'(conv_ref_ratio), e_cref);
    chk({tag, " out_enable"},     int'(out_enable),     e_oen);
    chk({tag, " cp_code"},        int'(cp_code),        e_cp);
    chk({tag, " gain_code"},      int'(gain_code),      e_gain);
    chk({tag, " main_ratio"},     int'(main_ratio),     e_main);
  endtask

  task automatic check_strobes(input string tag, input int r0, input int c0,
                               input int d0, input int dr, input int dc, input int dd);
    chk({tag, " ref_load count"}, n_ref - r0, dr);
    chk({tag, " ctl_load count"}, n_ctl - c0, dc);
    chk({tag, " div_load count"}, n_div - d0, dd);
  endtask

  task automatic t_reset();
    check_fields("R1 reset");
    chk("R1 strobes low", int'({ref_load, ctl_load, div_load}), 0);
  endtask

  // R5 plus R4 mid-frame hold and R9 strobe timing
  task automatic t_ref();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({18'd0, 12'b11_10_1010_0101, 2'b01}, 14);
    wait_sys(6);
    chk("R4 conv_ref_ratio before commit", int'(conv_ref_ratio), 0);
    chk("R4 no strobe before commit", n_ref - r0, 0);
    close_frame();
    check_fields("R5 ref word");
    chk("R5 conv_ref_ratio value", int'(conv_ref_ratio), 8'hA5);
    chk("R5 mod_ref_sel value", int'(mod_ref_sel), 2);
    check_strobes("R9 ref", r0, c0, d0, 1, 0, 0);
    chk("R9 field valid in ref strobe cycle", cap_cref, 8'hA5);
  endtask

  task automatic t_ctl_max();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({18'd0, 12'b111_1_101_11111, 2'b10}, 14);
    close_frame();
    check_fields("R6 ctl max");
    chk("R6 gain max", int'(gain_code), 31);
    chk("R10 ref untouched by ctl", int'(conv_ref_ratio), 8'hA5);
    check_strobes("R9 ctl", r0, c0, d0, 0, 1, 0);
    chk("R9 field valid in ctl strobe cycle", cap_gain, 31);
  endtask

  task automatic t_ctl_min();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({18'd0, 12'b000_0_011_00000, 2'b10}, 14);
    close_frame();
    check_fields("R6 ctl min");
    chk("R6 out_enable cleared", int'(out_enable), 0);
    check_strobes("R9 ctl min", r0, c0, d0, 0, 1, 0);
  endtask

  task automatic t_div();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({18'd0, 12'hC3A, 2'b11}, 14);
    close_frame();
    check_fields("R7 div");
    chk("R7 main_ratio value", int'(main_ratio), 12'hC3A);
    chk("R10 cp_code untouched by div", int'(cp_code), 3);
    check_strobes("R9 div", r0, c0, d0, 0, 0, 1);
    chk("R9 field valid in div strobe cycle", cap_main, 12'hC3A);
  endtask

  task automatic t_addr0();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({18'd0, 12'hFFF, 2'b00}, 14);
    close_frame();
    check_fields("R8 address 00");
    check_strobes("R8 address 00", r0, c0, d0, 0, 0, 0);
  endtask

  task automatic t_long();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    open_frame();
    shift_bits({14'd0, 4'b1011, 12'h5B7, 2'b11}, 18);
    close_frame();
    chk("R3 trailing 14 bits kept", int'(main_ratio), 12'h5B7);
    check_fields("R3 long frame");
    check_strobes("R3 long frame", r0, c0, d0, 0, 0, 1);
  endtask

  task automatic t_ignore_high();
    int r0 = n_ref, c0 = n_ctl, d0 = n_div;
    shift_bits(32'hFFFF_FFFF, 10);
    wait_sys(8);
    check_fields("R2 clocks while select high");
    check_strobes("R2 clocks while select high", r0, c0, d0, 0, 0, 0);
    open_frame();
    shift_bits({25'd0, 7'b0100110}, 7);
    close_frame();
    check_fields("R2 short frame after ignored clocks");
  endtask

  initial begin
    wait_sys(5);
    rst = 1'b0;
    wait_sys(3);
    t_reset();
    t_ref();
    t_ctl_max();
    t_ctl_min();
    t_div();
    t_addr0();
    t_long();
    t_ignore_high();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule